// File: doc/BRIEF.md
# Float/Integer Conversion Unit

This unit converts between 32-bit two's-complement integers and IEEE-754 single-precision values in both directions. An 8-bit operation code picks the direction. A 2-bit rounding field, normally taken from the floating-point control and status register, steers how an inexact result is rounded. The same field governs both directions, so software can change rounding behaviour without issuing a different operation.

A caller raises `start` for one cycle with the operand, the operation code and the rounding field. On the next cycle `valid` pulses and `result` carries the converted value. `result` then holds until the next accepted operation. Operations may be issued on consecutive cycles.

Converting a float to an integer handles every input class. NaN and out-of-range values saturate. Infinities saturate by sign. Denormals are treated as magnitudes below one and rounded in the selected mode.

Top module: `fcvt_unit`

## Requirements
- R1: Operation code 0x04 converts an integer to a float, and 0x05 converts a float to an integer. A `start` with any other code produces no `valid` pulse and leaves `result` unchanged.
- R2: After reset, `valid` is 0 and `result` is 0. An accepted `start` gives a one-cycle `valid` pulse on the following cycle. `result` holds its value in every cycle without an accepted `start`.
- R3: Integer-to-float rounds an operand with more than 24 significant bits according to `rmode`. The encodings are: 0 = nearest with ties to even, 1 = toward zero, 2 = toward +infinity, 3 = toward -infinity.
- R4: Integer-to-float is exact for magnitudes below 2^24. Zero gives +0.0 (0x00000000), and 0x80000000 gives exactly -2^31 (0xCF000000).
- R5: Float-to-integer rounds the fractional part in the mode selected by `rmode`, using the same encoding as R3. Ties round to the even integer in mode 0.
- R6: A float with biased exponent (bits 30:23) of 158 or above saturates. The result is 0x7FFFFFFF for sign bit 0 and 0x80000000 for sign bit 1; this covers the infinities and the exact value -2^31.
- R7: A NaN input (exponent 255, nonzero fraction bits 22:0) to float-to-integer gives 0x7FFFFFFF, whatever its sign.
- R8: Float inputs below 0.5 in magnitude, denormals included, give 0 unless the mode rounds away from zero in their direction. Mode 2 gives 1 for a positive input, and mode 3 gives 0xFFFFFFFF for a negative one.
- R9: Negative float-to-integer results are in two's complement. A nonzero result carries the sign of the input, and -0.0 gives 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Accepts the operation presented this cycle |
| op | input | 8 | Operation code (0x04 int-to-float, 0x05 float-to-int) |
| rmode | input | 2 | Rounding-mode field |
| operand | input | 32 | Integer or single-precision source value |
| result | output | 32 | Converted value, held between operations |
| valid | output | 1 | One-cycle strobe marking a new result |

## Verification
The assertions assume that `op`, `rmode` and `operand` carry defined values in every cycle after reset. They also assume that `start` may be high on any cycle, including back to back, with no spacing rule. The stimulus drives only defined values and changes them just after the rising edge. It mixes directed corner values (ties, carries out of the mantissa, saturation edges, NaN, denormals) with random operands. For float-to-integer, the random operands have their exponents pulled toward the range around the integer boundary.

// File: rtl/fcvt_pkg.sv
package fcvt_pkg;

  localparam int INT_W = 32;
  localparam int FP_W  = 32;
  localparam int EXP_W = 8;
  localparam int MAN_W = 23;
  localparam int BIAS  = 127;
  localparam int OPC_W = 8;
  localparam int SIG_W = MAN_W + 1;
  localparam int LOG_W = $clog2(INT_W);

  localparam logic [OPC_W-1:0] OPC_INT_TO_FP = 8'h04;
  localparam logic [OPC_W-1:0] OPC_FP_TO_INT = 8'h05;

  typedef enum logic [1:0] {
    RM_NEAREST_EVEN = 2'd0,
    RM_TO_ZERO      = 2'd1,
    RM_TO_POS       = 2'd2,
    RM_TO_NEG       = 2'd3
  } rmode_e;

  // Decide whether the kept magnitude is bumped by one unit in the last place.
  function automatic logic round_bump(rmode_e rm, logic neg, logic lsb,
                                      logic grd, logic stk);
    case (rm)
      RM_NEAREST_EVEN: return grd & (stk | lsb);
      RM_TO_ZERO:      return 1'b0;
      RM_TO_POS:       return (grd | stk) & ~neg;
      default:         return (grd | stk) & neg;
    endcase
  endfunction

  // Index of the highest set bit (0 for a zero input).
  function automatic logic [LOG_W-1:0] msb_index(logic [INT_W-1:0] v);
    logic [LOG_W-1:0] idx;
    idx = '0;
    for (int i = 0; i < INT_W; i++) begin
      if (v[i]) idx = LOG_W'(i);
    end
    return idx;
  endfunction

endpackage

// File: rtl/fcvt_int_to_fp.sv
module fcvt_int_to_fp
  import fcvt_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic [INT_W-1:0] src,
  input  rmode_e           rm,
  output logic [FP_W-1:0]  res
);

  localparam int GRD_POS = INT_W - 2 - MAN_W;

  logic             neg;
  logic [INT_W-1:0] mag;
  logic [INT_W-1:0] norm;
  logic [LOG_W-1:0] msb;
  logic [MAN_W-1:0] frac;
  logic             grd;
  logic             stk;
  logic             bump;
  logic [MAN_W:0]   frac_rnd;
  logic [EXP_W-1:0] exp_b;
  // named events for the assertions
  logic             inexact;
  logic             mant_carry;

  always_comb begin
    neg      = src[INT_W-1];
    mag      = neg ? (~src + INT_W'(1)) : src;
    msb      = msb_index(mag);
    norm     = mag << (LOG_W'(INT_W - 1) - msb);
    frac     = norm[INT_W-2 -: MAN_W];
    grd      = norm[GRD_POS];
    stk      = |norm[GRD_POS-1:0];
    bump     = round_bump(rm, neg, frac[0], grd, stk);
    frac_rnd = {1'b0, frac} + (MAN_W+1)'(bump);
    exp_b    = EXP_W'(BIAS) + EXP_W'(msb) + EXP_W'(frac_rnd[MAN_W]);
    res      = (mag == '0) ? '0 : {neg, exp_b, frac_rnd[MAN_W-1:0]};
    inexact    = grd | stk;
    mant_carry = frac_rnd[MAN_W];
  end

  AST_I2F_SHORT_EXACT: assert property (@(posedge clk) disable iff (!rst_n)
    (mag[INT_W-1:SIG_W] == '0) |-> !inexact); // R4

  AST_I2F_TRUNC_NO_CARRY: assert property (@(posedge clk) disable iff (!rst_n)
    (rm == RM_TO_ZERO) |-> !mant_carry); // R3

endmodule

// File: rtl/fcvt_fp_to_int.sv
module fcvt_fp_to_int
  import fcvt_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic [FP_W-1:0]  src,
  input  rmode_e           rm,
  output logic [INT_W-1:0] res
);

  localparam int E_SAT  = BIAS + INT_W - 1;
  localparam int E_INT  = BIAS + MAN_W;
  localparam int E_HALF = BIAS - 1;
  localparam int FX_W   = 2 * SIG_W + 1;

  logic             neg;
  logic [EXP_W-1:0] ex;
  logic [MAN_W-1:0] fr;
  logic [SIG_W-1:0] sig;
  logic [EXP_W-1:0] sh;
  logic [FX_W-1:0]  fixed;
  logic [INT_W-1:0] whole;
  logic             grd;
  logic             stk;
  logic             bump;
  logic [INT_W-1:0] mag_r;
  // named events for the assertions
  logic             is_nan;
  logic             out_of_range;
  logic             tiny;

  always_comb begin
    neg          = src[FP_W-1];
    ex           = src[FP_W-2 -: EXP_W];
    fr           = src[MAN_W-1:0];
    sig          = {ex != '0, fr};
    is_nan       = (ex == '1) && (fr != '0);
    out_of_range = ex >= EXP_W'(E_SAT);
    tiny         = ex < EXP_W'(E_HALF);
    whole        = '0;
    grd          = 1'b0;
    stk          = 1'b0;
    fixed        = '0;
    sh           = '0;
    if (ex >= EXP_W'(E_INT)) begin
      whole = INT_W'(sig) << (ex - EXP_W'(E_INT));
    end else if (!tiny) begin
      sh    = EXP_W'(E_INT) - ex;
      fixed = {sig, {(SIG_W+1){1'b0}}} >> sh;
      whole = INT_W'(fixed[FX_W-1 -: SIG_W]);
      grd   = fixed[SIG_W];
      stk   = |fixed[SIG_W-1:0];
    end else begin
      stk = |sig;
    end
    bump  = round_bump(rm, neg, whole[0], grd, stk);
    mag_r = whole + INT_W'(bump);
    if (is_nan) begin
      res = {1'b0, {(INT_W-1){1'b1}}};
    end else if (out_of_range) begin
      res = neg ? {1'b1, {(INT_W-1){1'b0}}} : {1'b0, {(INT_W-1){1'b1}}};
    end else begin
      res = neg ? (~mag_r + INT_W'(1)) : mag_r;
    end
  end

  AST_F2I_SIGN_MATCH: assert property (@(posedge clk) disable iff (!rst_n)
    (!is_nan && !out_of_range && res != '0) |-> (res[INT_W-1] == neg)); // R9

  AST_F2I_TINY_AT_MOST_ONE: assert property (@(posedge clk) disable iff (!rst_n)
    tiny |-> (mag_r <= INT_W'(1))); // R8

endmodule

// File: rtl/fcvt_unit.sv
module fcvt_unit
  import fcvt_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic [OPC_W-1:0] op,
  input  logic [1:0]       rmode,
  input  logic [INT_W-1:0] operand,
  output logic [INT_W-1:0] result,
  output logic             valid
);

  rmode_e           rm;
  logic [FP_W-1:0]  i2f_res;
  logic [INT_W-1:0] f2i_res;
  logic             is_i2f;
  logic             is_f2i;
  logic             accept;

  assign rm     = rmode_e'(rmode);
  assign is_i2f = (op == OPC_INT_TO_FP);
  assign is_f2i = (op == OPC_FP_TO_INT);
  assign accept = start && (is_i2f || is_f2i);

  fcvt_int_to_fp u_i2f (
    .clk   (clk),
    .rst_n (rst_n),
    .src   (operand),
    .rm    (rm),
    .res   (i2f_res)
  );

  fcvt_fp_to_int u_f2i (
    .clk   (clk),
    .rst_n (rst_n),
    .src   (operand),
    .rm    (rm),
    .res   (f2i_res)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      valid  <= 1'b0;
      result <= '0;
    end else begin
      valid <= accept;
      if (accept) result <= is_i2f ? i2f_res : f2i_res;
    end
  end

  AST_VALID_AFTER_START: assert property (@(posedge clk) disable iff (!rst_n)
    (start && (op == 8'h04 || op == 8'h05)) |=> valid); // R2

  AST_IDLE_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    !start |=> (!valid && $stable(result))); // R2

  AST_BAD_OPCODE_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
    (start && op != 8'h04 && op != 8'h05) |=> (!valid && $stable(result))); // R1

  AST_ZERO_TO_PLUS_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (start && op == 8'h04 && operand == 32'h0) |=> (result == 32'h0)); // R4

  AST_INT_MIN_EXACT: assert property (@(posedge clk) disable iff (!rst_n)
    (start && op == 8'h04 && operand == 32'h8000_0000) |=> (result == 32'hCF00_0000)); // R4

  AST_NAN_CLAMP: assert property (@(posedge clk) disable iff (!rst_n)
    (start && op == 8'h05 && operand[30:23] == 8'hFF && operand[22:0] != '0)
      |=> (result == 32'h7FFF_FFFF)); // R7

  AST_POS_SATURATE: assert property (@(posedge clk) disable iff (!rst_n)
    (start && op == 8'h05 && !operand[31] && operand[30:23] >= 8'd158)
      |=> (result == 32'h7FFF_FFFF)); // R6

endmodule

// File: tb/test_fcvt_unit.sv
module test_fcvt_unit;

  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start = 1'b0;
  logic [7:0]  op = 8'h00;
  logic [1:0]  rmode = 2'd0;
  logic [31:0] operand = 32'h0;
  logic [31:0] result;
  logic        valid;

  int    checks = 0;
  int    fails = 0;
  bit    mon_on = 1'b0;
  bit    done = 1'b0;
  logic        exp_valid;
  logic [31:0] exp_result;
  string cur_tag = "R2 idle";
  string exp_tag = "R2 reset";

  always #(CLK_PERIOD/2) clk = ~clk;

  fcvt_unit i_fcvt_unit (
    .clk     (clk),
    .rst_n   (rst_n),
    .start   (start),
    .op      (op),
    .rmode   (rmode),
    .operand (operand),
    .result  (result),
    .valid   (valid)
  );

  // ---------------- behavioural reference ----------------
  function automatic bit ref_up(int rm, bit neg, bit odd, longint r, longint div);
    if (r == 0) return 1'b0;
    case (rm)
      0: return (2 * r > div) || ((2 * r == div) && odd);
      1: return 1'b0;
      2: return !neg;
      default: return neg;
    endcase
  endfunction

  function automatic logic [31:0] ref_i2f(logic [31:0] a, int rm);
    longint v, m, div, q, r;
    int k;
    bit neg;
    logic [63:0] qb;
    v = longint'($signed(a));
    neg = (v < 0);
    m = neg ? -v : v;
    if (m == 0) return 32'h0;
    k = 0;
    while ((longint'(1) << (k + 1)) <= m) k++;
    if (k <= 23) begin
      q = m << (23 - k); r = 0; div = 1;
    end else begin
      div = longint'(1) << (k - 23);
      q = m / div; r = m % div;
    end
    if (ref_up(rm, neg, q[0], r, div)) q = q + 1;
    if (q == (longint'(1) << 24)) begin q = q >> 1; k++; end
    qb = q;
    return {neg, 8'(k + 127), qb[22:0]};
  endfunction

  function automatic logic [31:0] ref_f2i(logic [31:0] a, int rm);
    bit neg;
    int e, s;
    longint f, sig, q, r, div, val;
    neg = a[31];
    e = int'(a[30:23]);
    f = longint'(a[22:0]);
    if (e == 255 && f != 0) return 32'h7FFF_FFFF;
    if (e >= 158) return neg ? 32'h8000_0000 : 32'h7FFF_FFFF;
    if (e == 0) begin sig = f; e = 1; end
    else sig = f + (longint'(1) << 23);
    s = 150 - e;
    if (s <= 0) begin
      q = sig << (-s); r = 0; div = 1;
    end else begin
      if (s > 60) s = 60;
      div = longint'(1) << s;
      q = sig / div; r = sig % div;
    end
    if (ref_up(rm, neg, q[0], r, div)) q = q + 1;
    val = neg ? -q : q;
    return val[31:0];
  endfunction

  always @(posedge clk) begin
    if (!rst_n) begin
      exp_valid  <= 1'b0;
      exp_result <= 32'h0;
      exp_tag    <= "R2 reset";
    end else if (start && (op == 8'h04 || op == 8'h05)) begin
      exp_valid  <= 1'b1;
      exp_result <= (op == 8'h04) ? ref_i2f(operand, int'(rmode))
                                  : ref_f2i(operand, int'(rmode));
      exp_tag    <= cur_tag;
    end else begin
      exp_valid <= 1'b0;
      exp_tag   <= start ? "R1 unknown opcode ignored" : "R2 idle hold";
    end
  end

  task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
    end
  endtask

  always @(negedge clk) begin
    if (rst_n && mon_on) begin
      check({exp_tag, " valid"}, {31'b0, valid}, {31'b0, exp_valid});
      check({exp_tag, " result"}, result, exp_result);
    end
  end

  // ---------------- stimulus ----------------
  task automatic issue(logic [7:0] o, int rm, logic [31:0] a, string tag);
    @(posedge clk);
    #1;
    start   = 1'b1;
    op      = o;
    rmode   = 2'(rm);
    operand = a;
    cur_tag = tag;
  endtask

  task automatic idle(int n);
    for (int i = 0; i < n; i++) begin
      @(posedge clk);
      #1;
      start = 1'b0;
    end
  endtask

  task automatic summary();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      summary();
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    check("R2 reset valid", {31'b0, valid}, 32'h0);
    check("R2 reset result", result, 32'h0);
    @(posedge clk);
    #1;
    rst_n  = 1'b1;
    mon_on = 1'b1;
    idle(2);

    // R4 exact integer-to-float
    issue(8'h04, 0, 32'h0000_0000, "R4 zero to +0.0");
    issue(8'h04, 3, 32'h8000_0000, "R4 int min exact");
    issue(8'h04, 2, 32'h0000_0001, "R4 one");
    issue(8'h04, 1, 32'hFFFF_FFFF, "R4 minus one");
    issue(8'h04, 2, 32'h00FF_FFFF, "R4 24-bit exact");
    idle(1);
    // R3 integer-to-float rounding
    for (int m = 0; m < 4; m++) begin
      issue(8'h04, m, 32'h0100_0001, "R3 just above 2^24");
      issue(8'h04, m, 32'hFEFF_FFFF, "R3 negative inexact");
      issue(8'h04, m, 32'h0100_0003, "R3 tie to even up");
      issue(8'h04, m, 32'h7FFF_FFFF, "R3 mantissa carry");
    end
    idle(1);
    // R5 / R9 float-to-integer rounding and sign
    for (int m = 0; m < 4; m++) begin
      issue(8'h05, m, 32'h4020_0000, "R5 +2.5");
      issue(8'h05, m, 32'h4060_0000, "R5 +3.5");
      issue(8'h05, m, 32'hC020_0000, "R9 -2.5");
      issue(8'h05, m, 32'hC02C_CCCD, "R9 -2.7");
      issue(8'h05, m, 32'h3F00_0001, "R5 just above half");
    end
    issue(8'h05, 0, 32'h8000_0000, "R9 negative zero");
    issue(8'h05, 0, 32'h4EFF_FFFF, "R6 largest in range");
    // R6 saturation
    issue(8'h05, 0, 32'h4F00_0000, "R6 +2^31 saturates");
    issue(8'h05, 1, 32'hCF00_0000, "R6 -2^31 exact");
    issue(8'h05, 2, 32'hCF00_0001, "R6 below int min");
    issue(8'h05, 3, 32'h7F80_0000, "R6 +inf");
    issue(8'h05, 0, 32'hFF80_0000, "R6 -inf");
    // R7 NaN
    issue(8'h05, 0, 32'h7FC0_0000, "R7 quiet NaN");
    issue(8'h05, 3, 32'hFFC0_0001, "R7 negative NaN");
    issue(8'h05, 2, 32'h7F80_0001, "R7 signalling NaN");
    // R8 small magnitudes and denormals
    for (int m = 0; m < 4; m++) begin
      issue(8'h05, m, 32'h0000_0001, "R8 +denormal");
      issue(8'h05, m, 32'h8000_0001, "R8 -denormal");
      issue(8'h05, m, 32'h3F00_0000, "R8 +0.5 tie");
      issue(8'h05, m, 32'hBE80_0000, "R8 -0.25");
    end
    // R1 unknown opcodes interleaved with legal ones
    issue(8'h05, 0, 32'h4120_0000, "R1 legal before unknown");
    issue(8'h00, 0, 32'h1234_5678, "R1 unknown 0x00");
    issue(8'h06, 0, 32'h4120_0000, "R1 unknown 0x06");
    issue(8'h14, 2, 32'h0000_0009, "R1 unknown 0x14");
    idle(3);

    // random mix, back-to-back and gapped
    for (int n = 0; n < 3000; n++) begin
      logic [31:0] a;
      logic [7:0]  o;
      int sel;
      a = $urandom;
      sel = int'($urandom % 16);
      o = (sel < 7) ? 8'h04 : (sel < 15) ? 8'h05 : 8'($urandom);
      if (o == 8'h05 && ($urandom % 2) == 1) a[30:23] = 8'(120 + $urandom % 42);
      issue(o, int'($urandom % 4), a, "R3 R5 R6 random");
      if (($urandom % 4) == 0) idle(1);
    end
    idle(3);

    done = 1'b1;
    summary();
    $finish;
  end

endmodule